// File: doc/BRIEF.md
# Asynchronous Bus Cycle Termination Classifier

This block watches one asynchronous bus cycle at a time and decides how it ended. Once the address strobe opens a cycle, it samples the acknowledge, autovector acknowledge, error and hold inputs on every rising clock edge. The first edge that sees an acknowledge or an error is the trigger edge. One further edge, the late window, then collects an error or hold that arrives just after the acknowledge. After that window the block commits one of four outcomes and pulses a done strobe together with a two-bit termination code.

A built-in no-response monitor counts clock edges while a cycle is open. If the programmed period runs out without any acknowledge, it raises an internal error and ends the cycle as if the error input had been driven. A period of zero switches the monitor off. After a hold-type outcome the block keeps a halted flag high until the hold input is released, so the master can step one cycle at a time. Termination inputs that are still high when a new cycle opens are ignored until they drop.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset, `done_o`, `halted_o` and `timeout_o` are 0 and `code_o` is 0.
- R2: An acknowledge (`ack_i` or `autovec_i`) with `err_i` and `hold_i` low on both the trigger edge and the late-window edge gives code 0 (normal). `done_o` is high for exactly one cycle, starting after the second rising edge counted from the trigger edge.
- R3: `hold_i` high on the trigger edge, or on earlier edges that stay high through it, with `err_i` low on both edges, gives code 1 (halt).
- R4: `hold_i` that first goes high in the late window after an acknowledge, with no error, has no effect: the code is 0.
- R5: `err_i` high on the trigger edge, with or without an acknowledge, or high in the late window after an acknowledge, with `hold_i` low throughout, gives code 2 (bus error).
- R6: An error seen on the trigger or window edge, together with `hold_i` seen on the trigger or window edge, gives code 3 (retry).
- R7: After code 1, `halted_o` goes high together with `done_o`. It stays high while `hold_i` is sampled high and drops after the first rising edge that samples `hold_i` low.
- R8: With `mon_limit_i` = L > 0 and no acknowledge, `timeout_o` pulses for one cycle after the L-th rising edge that follows the edge opening the cycle. `done_o` follows one cycle later with code 2, or with code 3 if `hold_i` is high.
- R9: With `mon_limit_i` = 0, `timeout_o` never rises and the cycle stays open until an acknowledge or error arrives.
- R10: If `ack_i`, `autovec_i` or `err_i` is high when `strobe_i` opens a cycle, that level does not end the cycle. The cycle becomes active on the first rising edge that sees all three low.
- R11: Each cycle produces exactly one `done_o` pulse, and `done_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Address strobe: high while the master runs a cycle |
| ack_i | input | 1 | Data transfer acknowledge from the slave |
| autovec_i | input | 1 | Autovector acknowledge, treated like `ack_i` |
| err_i | input | 1 | External bus error |
| hold_i | input | 1 | External halt request |
| mon_limit_i | input | 16 | No-response period in clock edges; 0 disables the monitor |
| done_o | output | 1 | One-cycle strobe: outcome committed |
| code_o | output | 2 | 0 normal, 1 halt, 2 bus error, 3 retry; valid with `done_o`, held after it |
| halted_o | output | 1 | High after a halt outcome until `hold_i` is released |
| timeout_o | output | 1 | One-cycle pulse when the monitor forces an error |

## Verification
The hardest outcomes to reach are the ones that depend on when two inputs arrive relative to each other: a hold that lands one edge after the acknowledge, which must be ignored, and an error that lands in that same late edge, which must count. The stimulus drives every input half a period away from the sampling edge. For each random cycle it picks independently whether error and hold appear before, on, or one edge after the trigger. The monitor expiry and the stale-acknowledge case are reached with directed cycles that hold the inputs steady over a counted number of edges.

// File: rtl/bterm_pkg.sv
package bterm_pkg;

  typedef enum logic [1:0] {
    TERM_NORMAL = 2'd0,
    TERM_HALT   = 2'd1,
    TERM_BUSERR = 2'd2,
    TERM_RETRY  = 2'd3
  } term_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STALE,
    ST_ACTIVE,
    ST_WINDOW,
    ST_HALTED,
    ST_FINISH
  } seq_state_e;

  // err_seen  : error on trigger or window edge
  // halt_trig : hold sampled on the trigger edge
  // halt_any  : hold sampled on trigger or window edge
  function automatic term_code_e classify(input logic err_seen,
                                          input logic halt_trig,
                                          input logic halt_any);
    term_code_e r;
    if (err_seen && halt_any)  r = TERM_RETRY;
    else if (err_seen)         r = TERM_BUSERR;
    else if (halt_trig)        r = TERM_HALT;
    else                       r = TERM_NORMAL;
    return r;
  endfunction

endpackage

// File: rtl/bterm_monitor.sv
module bterm_monitor #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic period_hit(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] lim);
    return (lim != '0) && (({1'b0, cnt} + 1'b1) == {1'b0, lim});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !ack_i && period_hit(cnt_q, limit_i);

endmodule

// File: rtl/bterm_classifier.sv
module bterm_classifier
  import bterm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture_i,
  input  logic       window_i,
  input  logic       err_cap_i,
  input  logic       err_i,
  input  logic       hold_i,
  output term_code_e result_o,
  output logic       done_o,
  output term_code_e code_o
);

  logic e_q, h_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q <= 1'b0;
      h_q <= 1'b0;
    end else if (capture_i) begin
      e_q <= err_cap_i;
      h_q <= hold_i;
    end
  end

  assign result_o = classify(e_q | err_i, h_q, h_q | hold_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      code_o <= TERM_NORMAL;
    end else begin
      done_o <= window_i;
      if (window_i) code_o <= result_o;
    end
  end

endmodule

// File: rtl/bterm_seq.sv
module bterm_seq
  import bterm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_i,
  input  logic       busy_i,
  input  logic       trigger_i,
  input  term_code_e result_i,
  input  logic       hold_i,
  output logic       active_o,
  output logic       window_o,
  output logic       halted_o
);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (strobe_i) st_d = busy_i ? ST_STALE : ST_ACTIVE;
      ST_STALE:  if (!strobe_i) st_d = ST_IDLE;
                 else if (!busy_i) st_d = ST_ACTIVE;
      ST_ACTIVE: if (trigger_i) st_d = ST_WINDOW;
                 else if (!strobe_i) st_d = ST_IDLE;
      ST_WINDOW: st_d = (result_i == TERM_HALT) ? ST_HALTED : ST_FINISH;
      ST_HALTED: if (!hold_i) st_d = ST_FINISH;
      ST_FINISH: if (!strobe_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign active_o = (st_q == ST_ACTIVE);
  assign window_o = (st_q == ST_WINDOW);
  assign halted_o = (st_q == ST_HALTED);

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bterm_pkg::*;
#(
  parameter int MON_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             ack_i,
  input  logic             autovec_i,
  input  logic             err_i,
  input  logic             hold_i,
  input  logic [MON_W-1:0] mon_limit_i,
  output logic             done_o,
  output logic [1:0]       code_o,
  output logic             halted_o,
  output logic             timeout_o
);

  // named internal events
  logic       ack_any_w;
  logic       busy_w;
  logic       active_w;
  logic       window_w;
  logic       expire_w;
  logic       trigger_w;
  logic       err_cap_w;
  term_code_e result_w;
  term_code_e code_w;
  logic       timeout_q;

  assign ack_any_w = ack_i | autovec_i;
  assign busy_w    = ack_any_w | err_i;
  assign err_cap_w = err_i | expire_w;
  assign trigger_w = active_w & (ack_any_w | err_cap_w);

  bterm_monitor #(.CNT_W(MON_W)) mon_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (active_w),
    .ack_i    (ack_any_w),
    .limit_i  (mon_limit_i),
    .expire_o (expire_w)
  );

  bterm_classifier cls_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (trigger_w),
    .window_i  (window_w),
    .err_cap_i (err_cap_w),
    .err_i     (err_i),
    .hold_i    (hold_i),
    .result_o  (result_w),
    .done_o    (done_o),
    .code_o    (code_w)
  );

  bterm_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (strobe_i),
    .busy_i    (busy_w),
    .trigger_i (trigger_w),
    .result_i  (result_w),
    .hold_i    (hold_i),
    .active_o  (active_w),
    .window_o  (window_w),
    .halted_o  (halted_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timeout_q <= 1'b0;
    else        timeout_q <= expire_w;
  end

  assign timeout_o = timeout_q;
  assign code_o    = code_w;

endmodule

// File: rtl/bus_term_ctrl_chk.sv
module bus_term_ctrl_chk #(
  parameter int MON_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_i,
  input logic [MON_W-1:0] mon_limit_i,
  input logic             done_o,
  input logic [1:0]       code_o,
  input logic             halted_o,
  input logic             timeout_o
);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_halt_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && code_o == 2'd1) |-> halted_o);

  assert_halt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && hold_i) |=> halted_o);

  assert_other_no_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && code_o != 2'd1) |-> !halted_o);

  assert_timeout_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> (done_o && code_o[1]));

  assert_monitor_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mon_limit_i) == '0 && $stable(mon_limit_i)) |-> !timeout_o);

endmodule

bind bus_term_ctrl bus_term_ctrl_chk #(.MON_W(MON_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_i      (hold_i),
  .mon_limit_i (mon_limit_i),
  .done_o      (done_o),
  .code_o      (code_o),
  .halted_o    (halted_o),
  .timeout_o   (timeout_o)
);

// File: tb/bus_term_ctrl_tb_top.sv
module bus_term_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe_i = 1'b0, ack_i = 1'b0, autovec_i = 1'b0;
  logic        err_i = 1'b0, hold_i = 1'b0;
  logic [15:0] mon_limit_i = 16'd0;
  logic        done_o, halted_o, timeout_o;
  logic [1:0]  code_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  bus_term_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .ack_i(ack_i),
    .autovec_i(autovec_i), .err_i(err_i), .hold_i(hold_i),
    .mon_limit_i(mon_limit_i), .done_o(done_o), .code_o(code_o),
    .halted_o(halted_o), .timeout_o(timeout_o)
  );

  function automatic logic [1:0] exp_code(bit e, bit h_trig, bit h_any);
    if (e && h_any) return 2'd3;
    if (e)          return 2'd2;
    if (h_trig)     return 2'd1;
    return 2'd0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic close_cycle();
    ack_i = 0; autovec_i = 0; err_i = 0; hold_i = 0; strobe_i = 0;
    step();
    check(done_o == 0, "R11", done_o, 0);
    step();
  endtask

  // open a cycle: the entry edge is consumed, returns at the negedge after it
  task automatic open_cycle();
    strobe_i = 1;
    step();
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(done_o == 0 && halted_o == 0 && timeout_o == 0 && code_o == 0,
          "R1", {done_o, halted_o, timeout_o, code_o}, 0);
    rst_n = 1;
    step();
    mon_limit_i = 16'd1000;

    // R2 directed: autovector acknowledge, exact timing
    open_cycle();
    autovec_i = 1;
    @(posedge clk); @(negedge clk);
    check(done_o == 0, "R2", done_o, 0);
    step();
    check(done_o == 1 && code_o == 0, "R2", code_o, 0);
    step();
    check(done_o == 0 && code_o == 0, "R11", done_o, 0);
    close_cycle();

    // random cycles: R2..R6
    for (int n = 0; n < 80; n++) begin
      int  d    = int'($urandom % 3);
      bit  ack_t = bit'($urandom % 2);
      bit  err_t = bit'($urandom % 2);
      bit  err_l = ($urandom % 3) == 0;
      bit  h_e   = ($urandom % 3) == 0;
      bit  h_l   = ($urandom % 3) == 0;
      logic [1:0] ec;
      if (!ack_t && !err_t) ack_t = 1;
      if (!ack_t) err_l = 0;
      ec = exp_code(err_t | err_l, h_e, h_e | h_l);
      open_cycle();
      hold_i = h_e;
      for (int k = 0; k < d; k++) step();
      ack_i = ack_t; err_i = err_t;
      step();
      err_i = err_t | err_l; hold_i = h_e | h_l;
      step();
      check(done_o == 1, "R11", done_o, 1);
      case (ec)
        2'd0: check(code_o == ec, h_l ? "R4" : "R2", code_o, ec);
        2'd1: check(code_o == ec, "R3", code_o, ec);
        2'd2: check(code_o == ec, "R5", code_o, ec);
        default: check(code_o == ec, "R6", code_o, ec);
      endcase
      ack_i = 0; err_i = 0;
      if (ec == 2'd1) begin
        check(halted_o == 1, "R7", halted_o, 1);
        step();
        check(halted_o == 1, "R7", halted_o, 1);
        hold_i = 0;
        step();
        check(halted_o == 0, "R7", halted_o, 0);
      end else begin
        check(halted_o == 0, "R7", halted_o, 0);
      end
      close_cycle();
    end

    // R8: monitor expiry, L = 5
    mon_limit_i = 16'd5;
    open_cycle();
    for (int k = 1; k < 5; k++) begin
      step();
      check(done_o == 0 && timeout_o == 0, "R8", timeout_o, 0);
    end
    step();
    check(timeout_o == 1, "R8", timeout_o, 1);
    step();
    check(done_o == 1 && code_o == 2 && timeout_o == 0, "R8", code_o, 2);
    close_cycle();

    // R8: expiry with hold high gives retry
    mon_limit_i = 16'd3;
    open_cycle();
    hold_i = 1;
    step(); step(); step();
    check(timeout_o == 1, "R8", timeout_o, 1);
    step();
    check(done_o == 1 && code_o == 3, "R8", code_o, 3);
    close_cycle();

    // R9: monitor disabled
    mon_limit_i = 16'd0;
    open_cycle();
    begin
      int seen = 0;
      for (int k = 0; k < 40; k++) begin
        step();
        if (done_o || timeout_o) seen++;
      end
      check(seen == 0, "R9", seen, 0);
    end
    ack_i = 1;
    step(); step();
    check(done_o == 1 && code_o == 0, "R9", code_o, 0);
    close_cycle();

    // R10: stale acknowledge and error at cycle start
    mon_limit_i = 16'd1000;
    ack_i = 1; err_i = 1;
    open_cycle();
    begin
      int seen = 0;
      for (int k = 0; k < 4; k++) begin
        step();
        if (done_o) seen++;
      end
      check(seen == 0, "R10", seen, 0);
    end
    ack_i = 0; err_i = 0;
    step();
    check(done_o == 0, "R10", done_o, 0);
    ack_i = 1;
    step(); step();
    check(done_o == 1 && code_o == 0, "R10", code_o, 0);
    close_cycle();

    summary();
  end

endmodule